// File: doc/BRIEF.md
# Descending Memory Scan Engine

This engine carries out a search through a buffer in memory. It compares a search value against each element and walks the buffer from its highest element down to its base. The caller supplies the search value, a pointer that holds the buffer base minus one, and an index register that serves as both the element offset and the count of elements left. A mode input chooses between whole 16-bit words and 8-bit bytes. The engine reads one element at a time over a request/acknowledge memory port. Memory may stall the engine by holding back the acknowledge.

A scan ends in one of three ways. It stops on a match with no skip. It runs out of elements and asks for a one-word skip. Or an interrupt request suspends it between elements. In every case the index output holds the elements still below the stopping point. Starting again with the same pointer and that index value searches the rest of the buffer, whether the scan was suspended or stopped on a match.

Top module: `scan_engine`

## Requirements
- R1: On the first memory read after a start, the address is formed from pointer + index (16-bit sum). In word mode the 15-bit word address is the low 15 bits of that sum, so the first element read is the highest in the buffer.
- R2: The index output drops by exactly one in the clock edge that accepts each acknowledged read, and the compare result is registered in the same edge.
- R3: When an element equals the search value, the scan ends: `done` pulses for one cycle, `matched`=1 and `skip`=0. The index output equals the matched element's index minus one. A match on the last element (index 1) is a match with index 0, not a skip.
- R4: When the element at index 1 does not match, the scan ends with `done`, `skip`=1, `matched`=0 and index 0.
- R5: A new start with the same pointer and the index left by an earlier scan continues with the element just below the earlier stopping point.
- R6: In byte mode the 16-bit pointer + index is a byte address. The word address is its bits 15:1. An even byte address selects data bits 15:8 and an odd one selects bits 7:0. The byte is zero-extended and compared with all 16 bits of the search value, so a search value with a nonzero upper byte never matches.
- R7: If `irq` is high when a non-matching element that is not the last is acknowledged, the scan ends with `done` and `suspended`=1. The index output is left nonzero for a later resume.
- R8: A start with index 0 gives `done` with `skip`=1 in the next cycle, and no memory request is made.
- R9: A start while a scan is running is ignored. While a read is not acknowledged, `mem_req` and `mem_addr` stay unchanged.
- R10: After reset, `mem_req`, `busy`, `done`, `matched`, `skip`, `suspended` and the index output are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan (taken only when idle) |
| byte_mode | input | 1 | 1 = byte elements, 0 = word elements |
| a_in | input | 16 | Search value |
| x_in | input | 16 | Starting index / element count |
| ptr_in | input | 16 | Buffer base minus one |
| irq | input | 1 | Suspend request, sampled between elements |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 15 | Word address of the read |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse when a scan ends |
| matched | output | 1 | Last scan ended on a match |
| skip | output | 1 | Last scan ended with no match (one-word skip) |
| suspended | output | 1 | Last scan was suspended |
| x_out | output | 16 | Current index / elements remaining |

## Verification
Some properties are checked on every cycle. The index falls by one per acknowledged read. Each ending carries exactly one outcome. A skip leaves the index at zero and a suspension leaves it nonzero. A zero-length start ends at once with no request. A stalled request holds its address, a start during a scan changes nothing, and a byte compare never hits when the upper byte of the search value is set. Other behaviour can only be shown by the bench scenarios, run against a model of the buffer: which address is read first, how many reads a scan takes, where a resumed search picks up, which byte lane is chosen from the address parity, and that a match on the final element is not reported as a skip.

// File: rtl/scan_pkg.sv
// Shared types for the descending scan engine.
package scan_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_t;

    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_MATCH = 2'd1,
        OUT_SKIP  = 2'd2,
        OUT_SUSP  = 2'd3
    } scan_out_t;
endpackage

// File: rtl/scan_addr_gen.sv
// Forms the memory word address and byte lane for the current element.
// Assumes ADDR_W < DATA_W so a byte address fits in DATA_W bits.
module scan_addr_gen #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 15
) (
    input  logic [DATA_W-1:0] ptr,
    input  logic [DATA_W-1:0] idx,
    input  logic              byte_sel,
    output logic [ADDR_W-1:0] word_addr,
    output logic              lane_odd
);
    logic [DATA_W-1:0] sum;

    // Element address = pointer + index; byte mode halves it to a word address.
    always_comb begin
        sum       = ptr + idx;
        word_addr = byte_sel ? sum[ADDR_W:1] : sum[ADDR_W-1:0];
        lane_odd  = byte_sel & sum[0];
    end
endmodule

// File: rtl/scan_match.sv
// Compares the fetched element with the search value. In byte mode the
// selected byte is zero-extended before a full-width compare.
module scan_match #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] key,
    input  logic              byte_sel,
    input  logic              lane_odd,
    output logic              hit
);
    localparam int HALF = DATA_W / 2;

    logic [HALF-1:0]   lane;
    logic [DATA_W-1:0] cand;

    // Even byte address picks the upper half, odd picks the lower half.
    always_comb begin
        lane = lane_odd ? rdata[HALF-1:0] : rdata[DATA_W-1:HALF];
        cand = byte_sel ? {{(DATA_W-HALF){1'b0}}, lane} : rdata;
        hit  = (cand == key);
    end
endmodule

// File: rtl/scan_ctrl.sv
// Scan sequencer: latches the operands on start, issues one read per
// element, steps the index down and records how the scan ended.
// Assumes mem_ack is only meaningful while mem_req is high.
module scan_ctrl
    import scan_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] ptr_in,
    input  logic              irq,
    input  logic              mem_ack,
    input  logic              hit,
    output logic              mem_req,
    output logic              busy,
    output logic [DATA_W-1:0] x_q,
    output logic [DATA_W-1:0] a_q,
    output logic [DATA_W-1:0] ptr_q,
    output logic              byte_q,
    output logic              done,
    output logic              matched,
    output logic              skip,
    output logic              suspended
);
    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
    localparam logic [DATA_W-1:0] ZERO = '0;

    scan_state_t       state;
    scan_out_t         outcome;
    logic [DATA_W-1:0] x_nxt;

    // Index after the element being acknowledged.
    always_comb x_nxt = x_q - ONE;

    // Sequencer: operand capture, per-element stepping and ending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            outcome <= OUT_NONE;
            x_q     <= ZERO;
            a_q     <= ZERO;
            ptr_q   <= ZERO;
            byte_q  <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        a_q    <= a_in;
                        ptr_q  <= ptr_in;
                        byte_q <= byte_mode;
                        x_q    <= x_in;
                        if (x_in == ZERO) begin
                            outcome <= OUT_SKIP;
                            done    <= 1'b1;
                        end else begin
                            outcome <= OUT_NONE;
                            state   <= ST_SCAN;
                        end
                    end
                end
                default: begin
                    if (mem_ack) begin
                        x_q <= x_nxt;
                        if (hit) begin
                            outcome <= OUT_MATCH;
                            done    <= 1'b1;
                            state   <= ST_IDLE;
                        end else if (x_nxt == ZERO) begin
                            outcome <= OUT_SKIP;
                            done    <= 1'b1;
                            state   <= ST_IDLE;
                        end else if (irq) begin
                            outcome <= OUT_SUSP;
                            done    <= 1'b1;
                            state   <= ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // Status decode from the recorded ending.
    always_comb begin
        mem_req   = (state == ST_SCAN);
        busy      = (state == ST_SCAN);
        matched   = (outcome == OUT_MATCH);
        skip      = (outcome == OUT_SKIP);
        suspended = (outcome == OUT_SUSP);
    end

    AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && mem_ack) |=> (x_q == $past(x_q) - ONE)); // R2
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({matched, skip, suspended}) == 1)); // R3
    AST_SKIP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && skip) |-> (x_q == ZERO)); // R4
    AST_SUSP_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && suspended) |-> (x_q != ZERO)); // R7
    AST_ZERO_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && x_in == ZERO) |=> (done && skip && !mem_req)); // R8
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && start && !mem_ack) |=> (busy && $stable(x_q) && $stable(ptr_q))); // R9
endmodule

// File: rtl/scan_engine.sv
// Descending memory scan engine top. Reads elements from pointer + index
// downward until a match, exhaustion or a suspend request.
// Assumes memory answers each held request with mem_ack and valid data.
module scan_engine #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] ptr_in,
    input  logic              irq,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              matched,
    output logic              skip,
    output logic              suspended,
    output logic [DATA_W-1:0] x_out
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] x_q;
    logic [DATA_W-1:0] a_q;
    logic [DATA_W-1:0] ptr_q;
    logic              byte_q;
    logic              lane_odd;
    logic              hit;

    scan_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .byte_mode (byte_mode),
        .a_in      (a_in),
        .x_in      (x_in),
        .ptr_in    (ptr_in),
        .irq       (irq),
        .mem_ack   (mem_ack),
        .hit       (hit),
        .mem_req   (mem_req),
        .busy      (busy),
        .x_q       (x_q),
        .a_q       (a_q),
        .ptr_q     (ptr_q),
        .byte_q    (byte_q),
        .done      (done),
        .matched   (matched),
        .skip      (skip),
        .suspended (suspended)
    );

    scan_addr_gen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_addr (
        .ptr       (ptr_q),
        .idx       (x_q),
        .byte_sel  (byte_q),
        .word_addr (mem_addr),
        .lane_odd  (lane_odd)
    );

    scan_match #(.DATA_W(DATA_W)) u_match (
        .rdata    (mem_rdata),
        .key      (a_q),
        .byte_sel (byte_q),
        .lane_odd (lane_odd),
        .hit      (hit)
    );

    // Index register doubles as the remaining-count output.
    assign x_out = x_q;

    AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && byte_q && (a_q[DATA_W-1:HALF] != '0)) |-> !hit); // R6
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R9
endmodule

// File: tb/scan_engine_test.sv
// Scoreboard bench: the driver computes each scan's outcome from a model
// of the buffer and queues it; the monitor compares at every done pulse.
module scan_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 15;

    typedef struct {
        logic        m;
        logic        s;
        logic        u;
        logic [15:0] x;
        int          reads;
        logic [14:0] first;
        int          tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          byte_mode = 1'b0;
    logic [DW-1:0] a_in = '0;
    logic [DW-1:0] x_in = '0;
    logic [DW-1:0] ptr_in = '0;
    logic          irq = 1'b0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_ack;
    logic [DW-1:0] mem_rdata;
    logic          busy, done, matched, skip, suspended;
    logic [DW-1:0] x_out;

    logic [15:0] mem [256];
    logic        stall_en = 1'b0;
    logic        stall_ph;
    exp_t        sb_q[$];
    int          checks = 0;
    int          errors = 0;
    int          mon_reads = 0;
    logic [14:0] mon_first = '0;

    scan_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_mode(byte_mode),
        .a_in(a_in), .x_in(x_in), .ptr_in(ptr_in), .irq(irq),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .matched(matched),
        .skip(skip), .suspended(suspended), .x_out(x_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: combinational data, optional every-other-cycle stall.
    always_ff @(posedge clk) stall_ph <= (!rst_n) ? 1'b0 : ~stall_ph;
    assign mem_ack   = mem_req && (!stall_en || stall_ph);
    assign mem_rdata = mem[mem_addr[7:0]];

    task automatic check(input logic ok, input int tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Monitor: counts reads and scores each finished scan.
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_ack) begin
            if (mon_reads == 0) mon_first = mem_addr;
            mon_reads++;
        end
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, 9, "unexpected done (R9)", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(matched == e.m, e.tag, "matched (R3)", 32'(matched), 32'(e.m));
                check(skip == e.s, e.tag, "skip (R4)", 32'(skip), 32'(e.s));
                check(suspended == e.u, e.tag, "suspended (R7)", 32'(suspended), 32'(e.u));
                check(x_out == e.x, e.tag, "index (R2)", 32'(x_out), 32'(e.x));
                check(mon_reads == e.reads, e.tag, "read count", 32'(mon_reads), 32'(e.reads));
                if (e.reads > 0)
                    check(mon_first == e.first, e.tag, "first address (R1)",
                          32'(mon_first), 32'(e.first));
            end
            mon_reads = 0;
        end
    end

    // Driver: model the scan, queue the expectation, start the engine.
    task automatic run_scan(input logic [15:0] p, input logic [15:0] x,
                            input logic [15:0] a, input logic bm,
                            input logic irqv, input logic poke, input int tag);
        exp_t e;
        e.m = 0; e.s = 0; e.u = 0; e.x = 0; e.reads = 0; e.first = 0; e.tag = tag;
        if (x == 0) e.s = 1;
        for (int i = int'(x); i >= 1; i--) begin
            logic [15:0] b;
            logic [14:0] w;
            logic [15:0] v;
            b = p + 16'(i);
            w = bm ? b[15:1] : b[14:0];
            v = bm ? {8'h00, (b[0] ? mem[w[7:0]][7:0] : mem[w[7:0]][15:8])} : mem[w[7:0]];
            e.reads++;
            if (e.reads == 1) e.first = w;
            if (v == a) begin e.m = 1; e.x = 16'(i - 1); break; end
            if (i == 1) begin e.s = 1; e.x = 0; break; end
            if (irqv) begin e.u = 1; e.x = 16'(i - 1); break; end
        end
        sb_q.push_back(e);
        @(negedge clk);
        ptr_in = p; x_in = x; a_in = a; byte_mode = bm; irq = irqv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            ptr_in = 16'h0070; x_in = 16'h0000; start = 1'b1;   // R9: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        irq = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3 + 16'h0100);
        mem[8'h25] = 16'h1234;
        mem[8'h22] = 16'h1234;
        mem[8'h43] = 16'h5A77;
        mem[8'h51] = 16'h7777;

        repeat (3) @(negedge clk);
        // R10: reset state
        check(mem_req == 0, 10, "mem_req", 32'(mem_req), 0);
        check(busy == 0, 10, "busy", 32'(busy), 0);
        check(done == 0, 10, "done", 32'(done), 0);
        check({matched, skip, suspended} == 3'b000, 10, "status",
              32'({matched, skip, suspended}), 0);
        check(x_out == 0, 10, "x_out", 32'(x_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_scan(16'h0020, 16'd8, 16'h1234, 1'b0, 1'b0, 1'b0, 1);  // R1 word hit at index 5
        run_scan(16'h0020, 16'd4, 16'h1234, 1'b0, 1'b0, 1'b0, 5);  // R5 resume, hit at 2
        run_scan(16'h0020, 16'd1, 16'h1234, 1'b0, 1'b0, 1'b0, 5);  // R5 rest, no hit
        run_scan(16'h0010, 16'd6, 16'hBEEF, 1'b0, 1'b0, 1'b0, 4);  // R4 exhausted
        run_scan(16'h0050, 16'd3, 16'h7777, 1'b0, 1'b0, 1'b0, 3);  // R3 hit on last element
        run_scan(16'h0080, 16'd7, 16'h0077, 1'b1, 1'b0, 1'b0, 6);  // R6 odd -> low byte
        run_scan(16'h0080, 16'd6, 16'h005A, 1'b1, 1'b0, 1'b0, 6);  // R6 even -> high byte
        run_scan(16'h0080, 16'd7, 16'h0177, 1'b1, 1'b0, 1'b0, 6);  // R6 upper byte never hits
        run_scan(16'h0030, 16'd5, 16'hBEEF, 1'b0, 1'b1, 1'b0, 7);  // R7 suspend
        run_scan(16'h0030, 16'd4, 16'hBEEF, 1'b0, 1'b0, 1'b0, 7);  // R7 resume to end
        run_scan(16'h0030, 16'd0, 16'hBEEF, 1'b0, 1'b0, 1'b0, 8);  // R8 zero length
        stall_en = 1'b1;
        run_scan(16'h0020, 16'd8, 16'h1234, 1'b0, 1'b0, 1'b1, 9);  // R9 stalls + ignored start
        stall_en = 1'b0;
        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, 9, "pending results", 32'(sb_q.size()), 0);
        check(busy == 0, 9, "busy after ignored start", 32'(busy), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule